// File: doc/BRIEF.md
# Dual-Enable Static Memory Core

A clocked, synthesizable model of a byte-wide static memory with an asynchronous-style control set. Two chip enables of opposite polarity (`ce_n` active low, `ce` active high) must both be asserted for the part to be selected. Output enable `oe_n` and write enable `we_n` then choose the operation. The bidirectional data bus is split into `din`, `dout` and a drive enable `dout_en`. A pad ring or a bus wrapper can join these three into a tri-state pin.

On every rising clock edge the control pins are decoded into one of four modes, and the mode register takes the result. The four modes are:
- `MODE_DOWN`: deselected, power-down.
- `MODE_HIZ`: selected, drivers off.
- `MODE_READ`: driving read data.
- `MODE_WRITE`: write window open.

Every mode can move to every other mode in a single edge. The named transitions are:
- select: `MODE_DOWN` to any other mode.
- deselect: any mode to `MODE_DOWN`.
- write open: any mode to `MODE_WRITE`.
- write close: `MODE_WRITE` to `MODE_DOWN`, `MODE_HIZ` or `MODE_READ`, when either enable or `we_n` is released.
- read start: any mode to `MODE_READ`.
- read end: `MODE_READ` to any other mode.

While the write window is open, the byte on `din` is stored at `addr` on every edge. The last byte sampled before the window closes is therefore the one that stays in the array.

The array depth is a parameter. The default is a small array for simulation. Setting the parameter to 131072 gives the full 17-bit space. The array index is the low log2(`DEPTH`) bits of `addr`. Reset clears the mode register and the read register but not the array.

Top module: `dual_en_sram`

## Requirements
- R1: One clock after any edge where `ce_n`=1 or `ce`=0, `powered_down`=1. `powered_down` is never 1 while `dout_en`=1.
- R2: While deselected, `dout_en`=0 one clock later, whatever the values of `oe_n` and `we_n`.
- R3: When selected with `we_n`=0, the edge stores `din` at index `addr` mod `DEPTH`. The value of `oe_n` has no effect on the store.
- R4: One clock after an edge that samples an open write window, `dout_en`=0 and `powered_down`=0.
- R5: When selected with `oe_n`=0 and `we_n`=1, `dout_en`=1 one clock later and `dout` holds the array byte at `addr`.
- R6: When selected with `oe_n`=1 and `we_n`=1, one clock later `dout_en`=0 and `powered_down`=0.
- R7: With `we_n`=0 but `ce_n`=1 or `ce`=0, the array is left unchanged.
- R8: A write window held open for several edges leaves the `din` value sampled at its last open edge.
- R9: When an enable drops on the same edge as `we_n` returns high, `dout_en` stays 0 on the following cycle.
- R10: During reset, `powered_down`=1, `dout_en`=0 and `dout`=0. Array contents survive the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W (17) | Word address |
| din | input | WIDTH (8) | Write data from the bus |
| ce_n | input | 1 | Chip enable, active low |
| ce | input | 1 | Chip enable, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| dout | output | WIDTH (8) | Read data to the bus |
| dout_en | output | 1 | Bus drive enable; 0 means high impedance |
| powered_down | output | 1 | High while deselected |

## Verification
Every result lands one clock after the edge that samples its inputs:
- the mode flags and read data appear at that edge;
- a stored byte is visible to a read issued on the following edge.

The bench applies each input set just after a falling edge and lets one rising edge pass. It compares `dout_en`, `powered_down` and, when driving, `dout` at the next falling edge against a reference model that is updated for that same step. Because the model applies writes before a later read step, a read that directly follows a write window expects the new byte.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
    typedef enum logic [1:0] {
        MODE_DOWN  = 2'd0,
        MODE_HIZ   = 2'd1,
        MODE_READ  = 2'd2,
        MODE_WRITE = 2'd3
    } sram_mode_e;
endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
    import sram_ctl_pkg::*;
(
    input  logic       ce_n,
    input  logic       ce,
    input  logic       oe_n,
    input  logic       we_n,
    output sram_mode_e mode
);
    logic selected;
    assign selected = !ce_n && ce;

    // Write outranks read; oe_n is a don't-care once we_n is low (R3)
    always_comb begin
        if (!selected)
            mode = MODE_DOWN;
        else if (!we_n)
            mode = MODE_WRITE;
        else if (!oe_n)
            mode = MODE_READ;
        else
            mode = MODE_HIZ;
    end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Storage has no reset: contents persist across rst_n (R10)
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[idx] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= mem[idx];
    end
endmodule

// File: rtl/dual_en_sram.sv
module dual_en_sram
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DEPTH  = 1024,
    parameter int WIDTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  din,
    input  logic              ce_n,
    input  logic              ce,
    input  logic              oe_n,
    input  logic              we_n,
    output logic [WIDTH-1:0]  dout,
    output logic              dout_en,
    output logic              powered_down
);
    localparam int IDX_W = $clog2(DEPTH);

    sram_mode_e mode_d;
    sram_mode_e state_q;
    logic [IDX_W-1:0] idx;

    assign idx = addr[IDX_W-1:0];

    generate
        if (IDX_W < ADDR_W) begin : g_alias
            logic unused_hi_bits;
            assign unused_hi_bits = ^addr[ADDR_W-1:IDX_W];
        end
    endgenerate

    sram_mode_decode u_decode (
        .ce_n (ce_n),
        .ce   (ce),
        .oe_n (oe_n),
        .we_n (we_n),
        .mode (mode_d)
    );

    sram_array #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (mode_d == MODE_WRITE),
        .rd_en (mode_d == MODE_READ),
        .idx   (idx),
        .wdata (din),
        .rdata (dout)
    );

    // State register: every edge takes the decoded mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= MODE_DOWN;
        else
            state_q <= mode_d;
    end

    // Outputs from the registered state
    always_comb begin
        dout_en      = 1'b0;
        powered_down = 1'b0;
        unique case (state_q)
            MODE_DOWN:  powered_down = 1'b1;
            MODE_HIZ:   ;
            MODE_READ:  dout_en = 1'b1;
            MODE_WRITE: ;
            default:    powered_down = 1'b1;
        endcase
    end

    assert_deselect_pd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || !ce) |=> powered_down);

    always_comb begin
        assert_drive_excl_R1: assert (!(dout_en && powered_down));
    end

    assert_standby_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || !ce) |=> !dout_en);

    assert_write_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && ce && !we_n) |=> (!dout_en && !powered_down));

    assert_read_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && ce && !oe_n && we_n) |=> dout_en);

    assert_active_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && ce && oe_n && we_n) |=> (!dout_en && !powered_down));

    assert_close_no_glitch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_WRITE && we_n && (ce_n || !ce)) |=> !dout_en);
endmodule

// File: tb/sim_dual_en_sram.sv
module sim_dual_en_sram;
    localparam int PERIOD = 10;
    localparam int ADDR_W = 17;
    localparam int DEPTH  = 1024;
    localparam int WIDTH  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [WIDTH-1:0]  din = '0;
    logic              ce_n = 1'b1;
    logic              ce = 1'b0;
    logic              oe_n = 1'b1;
    logic              we_n = 1'b1;
    logic [WIDTH-1:0]  dout;
    logic              dout_en;
    logic              powered_down;

    int checks = 0;
    int errors = 0;
    logic [WIDTH-1:0] ref_mem [int];

    always #(PERIOD/2) clk = ~clk;

    dual_en_sram #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .ce_n(ce_n), .ce(ce), .oe_n(oe_n), .we_n(we_n),
        .dout(dout), .dout_en(dout_en), .powered_down(powered_down)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One step: inputs applied after a falling edge, results checked at the next one
    task automatic step(input logic s_ce_n, input logic s_ce, input logic s_oe_n,
                        input logic s_we_n, input int s_addr, input int s_din,
                        input string req);
        logic sel, rd, wr;
        int key;
        logic known;
        logic [WIDTH-1:0] exp_d;
        ce_n = s_ce_n; ce = s_ce; oe_n = s_oe_n; we_n = s_we_n;
        addr = s_addr[ADDR_W-1:0]; din = s_din[WIDTH-1:0];
        sel = !s_ce_n && s_ce;
        wr  = sel && !s_we_n;
        rd  = sel && s_we_n && !s_oe_n;
        key = s_addr % DEPTH;
        known = ref_mem.exists(key);
        exp_d = known ? ref_mem[key] : '0;
        if (wr) ref_mem[key] = s_din[WIDTH-1:0];
        @(posedge clk);
        @(negedge clk);
        chk({req, " powered_down"}, int'(powered_down), int'(!sel));
        chk({req, " dout_en"}, int'(dout_en), int'(rd));
        if (rd && known)
            chk({req, " dout"}, int'(dout), int'(exp_d));
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R10: reset state
        @(negedge clk);
        @(negedge clk);
        chk("R10 reset powered_down", int'(powered_down), 1);
        chk("R10 reset dout_en", int'(dout_en), 0);
        chk("R10 reset dout", int'(dout), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: writes, oe_n ignored
        step(0, 1, 1, 0, 5, 8'hA5, "R3 write oe_n high");
        step(0, 1, 0, 0, 6, 8'h3C, "R3 write oe_n low");
        // R5: read back
        step(0, 1, 0, 1, 5, 0, "R5 read 5");
        step(0, 1, 0, 1, 6, 0, "R5 read 6");
        // R6: selected, outputs off
        step(0, 1, 1, 1, 5, 0, "R6 active hiz");
        // R2: deselected in both ways with read/write attempts
        step(1, 1, 0, 1, 5, 0, "R2 ce_n high read");
        step(0, 0, 0, 1, 5, 0, "R2 ce low read");
        // R7: write attempts while deselected leave contents
        step(1, 1, 0, 0, 5, 8'h11, "R7 ce_n high write");
        step(0, 0, 1, 0, 5, 8'h22, "R7 ce low write");
        step(0, 1, 0, 1, 5, 0, "R7 readback");
        chk("R7 unchanged", int'(dout), 8'hA5);
        // R8: multi-cycle window, last data kept, closed by ce
        step(0, 1, 1, 0, 9, 8'h01, "R4 window c1");
        step(0, 1, 1, 0, 9, 8'h02, "R4 window c2");
        step(0, 1, 1, 0, 9, 8'h7E, "R4 window c3");
        step(0, 0, 1, 1, 9, 8'hFF, "R9 close ce with we_n rise");
        step(0, 1, 0, 1, 9, 0, "R8 readback");
        chk("R8 last data", int'(dout), 8'h7E);
        // R9: window closed by ce_n together with we_n rising, oe_n low
        step(0, 1, 0, 0, 12, 8'h44, "R4 write oe low");
        step(1, 1, 0, 1, 12, 0, "R9 close ce_n with we_n rise");
        chk("R9 no drive", int'(dout_en), 0);
        // write closed by we_n straight into read
        step(0, 1, 0, 0, 13, 8'h55, "R4 write then read");
        step(0, 1, 0, 1, 13, 0, "R5 read after close");
        // R3: aliasing of address modulo DEPTH
        step(0, 1, 1, 0, DEPTH + 20, 8'h9B, "R3 alias write");
        step(0, 1, 0, 1, 20, 0, "R3 alias read");
        chk("R3 alias data", int'(dout), 8'h9B);

        // Truth-table sweep plus random traffic over a small address set
        for (int i = 0; i < 400; i++) begin
            logic [3:0] c;
            c = 4'($urandom);
            step(c[0] & c[1], 1'b1 ^ (c[2] & c[3] & c[0]), c[2], c[3] & c[1],
                 int'($urandom % 16), int'($urandom % 256), "R1 random");
        end
        for (int c = 0; c < 16; c++) begin
            step(c[0], c[1], c[2], c[3], 3, c * 7, "R1 truth table");
        end

        // R10: contents survive reset
        step(0, 1, 1, 0, 30, 8'hC3, "R10 pre-reset write");
        ce_n = 1'b1; ce = 1'b0; we_n = 1'b1; oe_n = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 mid reset powered_down", int'(powered_down), 1);
        chk("R10 mid reset dout_en", int'(dout_en), 0);
        chk("R10 mid reset dout", int'(dout), 0);
        rst_n = 1'b1;
        @(negedge clk);
        step(0, 1, 0, 1, 30, 0, "R10 post-reset read");
        chk("R10 kept data", int'(dout), 8'hC3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule